// File: doc/BRIEF.md
# Prescaled Modulo Timebase Counter

This block is the common time reference for a group of timer channels. A 16-bit up-counter advances once per tick and returns to zero after reaching a programmable modulo value. Ticks come from the bus clock through a power-of-two divider, or from an external clock pin. That pin is synchronized, and pulses shorter than two bus clocks are filtered out. Each return to zero gives the channels a one-cycle strobe. It also sets an overflow flag, which raises an interrupt request when enabled.

Software reaches the block through a small synchronous 8-bit register bus. Five byte registers hold control/status, the counter high and low bytes, and the modulo high and low bytes. The counter can be halted or cleared. A 16-bit count read as two bytes is coherent. A modulo update split across two byte writes cannot raise a spurious overflow flag in between.

Top module: `tbase_timer`

## Requirements
- R1: With rate code c in 0..6 (control bits 2:0), the counter advances by one every 2^c running clock cycles, counted from a clear. After k+1 running edges from a clear, with no wrap, the count is (k+1) >> c.
- R2: With rate code 7 the counter advances once per qualified rising edge of `ext_clk_i`. A high or low level lasting fewer than two bus clock cycles is ignored.
- R3: On a tick where the count equals the modulo value, the count becomes 0 and `ovf_o` pulses high for one cycle.
- R4: After reset, the control register (address 0) reads 0x20, so the block is halted. The modulo bytes (addresses 3 and 4) read 0xFF, the count is 0, and `irq_o` is 0.
- R5: Writing control with bit 4 = 1 clears both the counter and the prescaler at that edge. Bit 4 always reads 0. With halt also set, the count stays 0.
- R6: The overflow flag (control bit 7) is set on every wrap. It is cleared only by a control read that sees it set, followed by a control write with bit 7 = 0. A control write without that prior read does not clear it. A wrap between the read and the write cancels the clear.
- R7: Reading the counter high byte (address 1) captures the low byte. The next read of address 2 returns the captured byte. Later reads of address 2 return the live low byte.
- R8: A write to the modulo high byte (address 3) blocks the overflow flag from setting until the modulo low byte (address 4) is written.
- R9: `irq_o` is high exactly when the overflow flag and the interrupt enable (control bit 6) are both 1.
- R10: While halt (control bit 5) is 1, the counter and prescaler keep their values and `ovf_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_clk_i | input | 1 | External clock pin, asynchronous |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_wr_i | input | 1 | Write strobe, one cycle per access |
| bus_rd_i | input | 1 | Read strobe, one cycle per access |
| bus_rdata_o | output | 8 | Read data, valid the cycle after the strobe |
| cnt_o | output | 16 | Live count to the channels |
| ovf_o | output | 1 | One-cycle wrap strobe to the channels |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
The bench goes after the clear handshake of the overflow flag, including a wrap that lands between the arming read and the clearing write. A design missing that guard would drop an overflow that software never saw. It checks that a prescaler keeps its phase across a halt: one that kept running while halted would produce a different tick count. It reads the counter as a byte pair while it runs. A missing capture latch would return a low byte two counts ahead. It also checks the external-clock filter with single-cycle glitches and dips: an unfiltered input would overcount. Finally, it runs wraps with the modulo high byte freshly written, where a missing inhibit would raise a flag that software did not expect.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADR_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_CNT_HI = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_CNT_LO = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_MOD_HI = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_MOD_LO = 3'd4;
  // control register bit positions
  localparam int B_FLAG = 7;
  localparam int B_IE   = 6;
  localparam int B_HALT = 5;
  localparam int B_ZAP  = 4;
endpackage

// File: rtl/tbase_extsync.sv
module tbase_extsync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic rise_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic last_q, flt_q, flt_d_q;
  logic smp;

  assign smp = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= '0;
      last_q  <= 1'b0;
      flt_q   <= 1'b0;
      flt_d_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      last_q <= smp;
      // level changes only after two equal samples in a row
      if (smp && last_q)        flt_q <= 1'b1;
      else if (!smp && !last_q) flt_q <= 1'b0;
      flt_d_q <= flt_q;
    end
  end

  assign rise_o = flt_q & ~flt_d_q;
endmodule

// File: rtl/tbase_prescaler.sv
module tbase_prescaler #(
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  input  logic              clr_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              ext_rise_i,
  output logic              tick_o
);
  localparam int PRE_W = (1 << RATE_W) - 2;
  localparam logic [RATE_W-1:0] EXT_CODE = '1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  assign mask = ~({PRE_W{1'b1}} << rate_i);

  always_ff @(posedge clk) begin
    if (rst || clr_i) pre_q <= '0;
    else if (run_i)   pre_q <= pre_q + PRE_W'(1);
  end

  assign tick_o = (rate_i == EXT_CODE) ? ext_rise_i : ((pre_q & mask) == mask);
endmodule

// File: rtl/tbase_count.sv
module tbase_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] mod_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             wrap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      wrap_q <= 1'b0;
      if (clr_i) begin
        cnt_q <= '0;
      end else if (run_i && tick_i) begin
        if (cnt_q == mod_i) begin
          cnt_q  <= '0;
          wrap_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = wrap_q;
endmodule

// File: rtl/tbase_regs.sv
module tbase_regs
  import tbase_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8,
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              wrap_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              halt_o,
  output logic              zap_o,
  output logic [RATE_W-1:0] rate_o,
  output logic [CNT_W-1:0]  mod_o,
  output logic              flag_o,
  output logic              inhibit_o,
  output logic              irq_o
);
  logic              flag_q, arm_q, ie_q, halt_q, inhibit_q, hold_vld_q;
  logic [RATE_W-1:0] rate_q;
  logic [CNT_W-1:0]  mod_q;
  logic [DATA_W-1:0] hold_q, rdata_q, ctrl_word;
  logic              ctrl_wr, ctrl_rd;

  assign ctrl_wr = wr_i && (addr_i == ADR_CTRL);
  assign ctrl_rd = rd_i && (addr_i == ADR_CTRL);
  assign zap_o   = ctrl_wr && wdata_i[B_ZAP];

  always_comb begin
    ctrl_word             = '0;
    ctrl_word[B_FLAG]     = flag_q;
    ctrl_word[B_IE]       = ie_q;
    ctrl_word[B_HALT]     = halt_q;
    ctrl_word[RATE_W-1:0] = rate_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q     <= 1'b0;
      arm_q      <= 1'b0;
      ie_q       <= 1'b0;
      halt_q     <= 1'b1;
      inhibit_q  <= 1'b0;
      hold_vld_q <= 1'b0;
      rate_q     <= '0;
      mod_q      <= '1;
      hold_q     <= '0;
      rdata_q    <= '0;
    end else begin
      if (ctrl_wr) begin
        ie_q   <= wdata_i[B_IE];
        halt_q <= wdata_i[B_HALT];
        rate_q <= wdata_i[RATE_W-1:0];
      end
      // a wrap wins over a pending clear and disarms it
      if (wrap_i && !inhibit_q) begin
        flag_q <= 1'b1;
        arm_q  <= 1'b0;
      end else if (ctrl_wr) begin
        if (arm_q && !wdata_i[B_FLAG]) flag_q <= 1'b0;
        arm_q <= 1'b0;
      end else if (ctrl_rd && flag_q) begin
        arm_q <= 1'b1;
      end
      if (wr_i && addr_i == ADR_MOD_HI) begin
        mod_q[CNT_W-1:DATA_W] <= wdata_i;
        inhibit_q             <= 1'b1;
      end
      if (wr_i && addr_i == ADR_MOD_LO) begin
        mod_q[DATA_W-1:0] <= wdata_i;
        inhibit_q         <= 1'b0;
      end
      if (rd_i) begin
        case (addr_i)
          ADR_CTRL:   rdata_q <= ctrl_word;
          ADR_CNT_HI: begin
            rdata_q    <= cnt_i[CNT_W-1:DATA_W];
            hold_q     <= cnt_i[DATA_W-1:0];
            hold_vld_q <= 1'b1;
          end
          ADR_CNT_LO: begin
            rdata_q    <= hold_vld_q ? hold_q : cnt_i[DATA_W-1:0];
            hold_vld_q <= 1'b0;
          end
          ADR_MOD_HI: rdata_q <= mod_q[CNT_W-1:DATA_W];
          ADR_MOD_LO: rdata_q <= mod_q[DATA_W-1:0];
          default:    rdata_q <= '0;
        endcase
      end
    end
  end

  assign rdata_o   = rdata_q;
  assign halt_o    = halt_q;
  assign rate_o    = rate_q;
  assign mod_o     = mod_q;
  assign flag_o    = flag_q;
  assign inhibit_o = inhibit_q;
  assign irq_o     = flag_q & ie_q;
endmodule

// File: rtl/tbase_timer.sv
module tbase_timer
  import tbase_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DATA_W      = 8,
  parameter int RATE_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_clk_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              ovf_o,
  output logic              irq_o
);
  logic              halt_w, zap_w, rise_w, tick_w, wrap_w, flag_w, inhibit_w;
  logic [RATE_W-1:0] rate_w;
  logic [CNT_W-1:0]  mod_w, cnt_w;

  tbase_extsync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_i(ext_clk_i), .rise_o(rise_w)
  );

  tbase_prescaler #(.RATE_W(RATE_W)) u_pre (
    .clk(clk), .rst(rst), .run_i(!halt_w), .clr_i(zap_w),
    .rate_i(rate_w), .ext_rise_i(rise_w), .tick_o(tick_w)
  );

  tbase_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .run_i(!halt_w), .clr_i(zap_w), .tick_i(tick_w),
    .mod_i(mod_w), .cnt_o(cnt_w), .wrap_o(wrap_w)
  );

  tbase_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .RATE_W(RATE_W)) u_regs (
    .clk(clk), .rst(rst), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .wr_i(bus_wr_i), .rd_i(bus_rd_i), .cnt_i(cnt_w), .wrap_i(wrap_w),
    .rdata_o(bus_rdata_o), .halt_o(halt_w), .zap_o(zap_w), .rate_o(rate_w),
    .mod_o(mod_w), .flag_o(flag_w), .inhibit_o(inhibit_w), .irq_o(irq_o)
  );

  assign cnt_o = cnt_w;
  assign ovf_o = wrap_w;
endmodule

// File: rtl/tbase_timer_chk.sv
module tbase_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             halt,
  input logic             zap,
  input logic             inhibit,
  input logic             flag,
  input logic             ovf,
  input logic [CNT_W-1:0] cnt
);
  AST_ZAP_CLEARS: assert property (@(posedge clk) disable iff (rst)
    zap |=> (cnt == '0)); // R5
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (halt && !zap) |=> $stable(cnt)); // R10
  AST_NO_STROBE_HALTED: assert property (@(posedge clk) disable iff (rst)
    halt |=> !ovf); // R10
  AST_WRAP_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    ovf |-> (cnt == '0)); // R3
  AST_FLAG_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
    (ovf && !inhibit) |=> flag); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (inhibit && !flag) |=> !flag); // R8
endmodule

bind tbase_timer tbase_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .halt(halt_w), .zap(zap_w), .inhibit(inhibit_w),
  .flag(flag_w), .ovf(ovf_o), .cnt(cnt_o)
);

// File: tb/sim_tbase_timer.sv
module sim_tbase_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ext_clk_i = 1'b0;
  logic [2:0]  bus_addr_i = '0;
  logic [7:0]  bus_wdata_i = '0;
  logic        bus_wr_i = 1'b0;
  logic        bus_rd_i = 1'b0;
  logic [7:0]  bus_rdata_o;
  logic [15:0] cnt_o;
  logic        ovf_o, irq_o;

  int n_chk = 0, n_fail = 0, n_ovf = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tbase_timer u0 (
    .clk(clk), .rst(rst), .ext_clk_i(ext_clk_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_wr_i(bus_wr_i), .bus_rd_i(bus_rd_i),
    .bus_rdata_o(bus_rdata_o), .cnt_o(cnt_o), .ovf_o(ovf_o), .irq_o(irq_o)
  );

  always @(negedge clk) if (!rst && ovf_o) n_ovf++;

  function automatic int exp_ticks(int k, int rate);
    return (k + 1) >> rate;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // tasks start and end at a falling edge and span exactly one rising edge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1'b1;
    @(negedge clk);
    bus_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr_i = a; bus_rd_i = 1'b1;
    @(negedge clk);
    bus_rd_i = 1'b0;
    d = bus_rdata_o;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input int hi, input int lo);
    ext_clk_i = 1'b1; idle(hi);
    ext_clk_i = 1'b0; idle(lo);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] d, hi, lo;
    int rate, k, m, c, n;
    void'($urandom(32'd4242));
    idle(4);
    rst = 1'b0;
    idle(1);

    // R4 reset state
    rd(0, d); check("R4 ctrl", d, 8'h20);
    rd(3, d); check("R4 mod hi", d, 8'hFF);
    rd(4, d); check("R4 mod lo", d, 8'hFF);
    check("R4 count", cnt_o, 0);
    check("R4 irq", irq_o, 0);

    // R1 random divide ratios
    for (int it = 0; it < 8; it++) begin
      rate = $urandom % 7;
      k = $urandom % 200;
      wr(0, 8'h30 | 8'(rate));
      wr(0, 8'(rate));
      idle(k);
      wr(0, 8'h20 | 8'(rate));
      idle(3);
      check("R1 count", cnt_o, exp_ticks(k, rate));
      rd(1, hi); rd(2, lo);
      check("R1 bus count", {hi, lo}, exp_ticks(k, rate));
    end

    // R10 prescaler phase held across halt, rate 6 (divide by 64)
    wr(0, 8'h36); wr(0, 8'h06); idle(39); wr(0, 8'h26);
    idle(100);
    wr(0, 8'h06); idle(29); wr(0, 8'h26); idle(2);
    check("R10 prescaler frozen", cnt_o, 1);

    // R3 wraps with random modulo
    for (int it = 0; it < 4; it++) begin
      m = $urandom % 10 + 2;
      k = $urandom % 60 + 12;
      wr(3, 8'h00); wr(4, 8'(m));
      wr(0, 8'h30);
      n_ovf = 0;
      wr(0, 8'h00); idle(k); wr(0, 8'h20); idle(3);
      check("R3 count after wraps", cnt_o, (k + 1) % (m + 1));
      check("R3 strobe count", n_ovf, (k + 1) / (m + 1));
    end

    // R10 halted: no change, no strobe
    c = cnt_o; n = n_ovf;
    idle(30);
    check("R10 count stable", cnt_o, c);
    check("R10 no strobe", n_ovf, n);

    // R6 flag clear protocol
    rd(0, d); check("R6 flag set by wrap", d[7], 1);
    wr(0, 8'hA0);                // bit7=1: no clear, disarms
    wr(0, 8'h20);                // not armed: no clear
    rd(0, d); check("R6 write without read", d, 8'hA0);
    wr(0, 8'h20);
    rd(0, d); check("R6 read then write clears", d, 8'h20);

    // R6 wrap between arming read and write
    wr(3, 8'h00); wr(4, 8'd20);
    wr(0, 8'h30); wr(0, 8'h00); idle(22);
    rd(0, d); check("R6 flag seen before race", d[7], 1);
    idle(20);
    wr(0, 8'h20);
    rd(0, d); check("R6 wrap cancels clear", d[7], 1);
    wr(0, 8'h20);
    rd(0, d); check("R6 clear after race", d, 8'h20);

    // R8 high-byte write inhibits flag
    wr(3, 8'h00);
    n = n_ovf;
    wr(0, 8'h30); wr(0, 8'h00); idle(50); wr(0, 8'h20); idle(3);
    check("R8 strobes still run", (n_ovf > n) ? 1 : 0, 1);
    rd(0, d); check("R8 flag inhibited", d, 8'h20);
    wr(4, 8'd20);
    wr(0, 8'h30); wr(0, 8'h00); idle(30); wr(0, 8'h20); idle(3);
    rd(0, d); check("R8 flag after low write", d, 8'hA0);

    // R9 interrupt request
    check("R9 irq masked", irq_o, 0);
    wr(0, 8'hE0); idle(1);
    check("R9 irq raised", irq_o, 1);
    rd(0, d); wr(0, 8'h60); idle(1);
    check("R9 irq drops with flag", irq_o, 0);
    wr(0, 8'h20);

    // R7 coherent byte-pair read while running
    wr(3, 8'hFF); wr(4, 8'hFF);
    wr(0, 8'h30); wr(0, 8'h00); idle(300);
    rd(1, hi);
    wr(0, 8'h20);
    rd(2, lo);
    c = cnt_o;
    check("R7 captured pair", {hi, lo}, c - 2);
    rd(2, lo);
    check("R7 live low after capture used", lo, c & 8'hFF);

    // R2 external clock with glitches and a dip
    wr(0, 8'h37); wr(0, 8'h07);
    for (int i = 0; i < 3; i++) pulse(1, 5);
    for (int i = 0; i < 4; i++) pulse(3, 5);
    ext_clk_i = 1'b1; idle(4); ext_clk_i = 1'b0; idle(1);
    ext_clk_i = 1'b1; idle(4); ext_clk_i = 1'b0; idle(8);
    wr(0, 8'h27); idle(2);
    check("R2 qualified edges", cnt_o, 5);

    // R5 clear, halted and running
    wr(0, 8'h00); idle(40);
    wr(0, 8'h30); idle(2);
    check("R5 cleared", cnt_o, 0);
    rd(0, d); check("R5 bit reads zero", d & 8'h7F, 8'h20);
    idle(20);
    check("R5 held at zero", cnt_o, 0);
    wr(0, 8'h00); idle(50);
    wr(0, 8'h10); wr(0, 8'h20); idle(2);
    check("R5 clear while running", cnt_o, 1);

    done = 1;
    summary();
    $finish;
  end
endmodule